// File: doc/BRIEF.md
# Receive FIFO Packet Framer

This block sits between the receive side of an Ethernet MAC and a 32-bit processor read port. The MAC hands it frames one byte per cycle, marking the first and the last byte and giving a 16-bit status word with the last byte. The block packs the bytes into 32-bit words in a word FIFO. When a frame is complete, it writes two header words into slots it reserved in front of the payload: a fixed signature word and a word that packs length and status. Only then does the frame become visible to the reader. Software reads header and payload one word at a time through a single data port. It checks the signature to detect loss of framing and uses the length to know how many payload words follow.

A frame counter reports how many complete frames are waiting, and a level interrupt follows that counter. Software can zero the counter. A flush command empties the FIFO, abandons any frame still arriving, and shows a busy flag for the cycle in which it completes. Frames that are too short, or that do not fit in the free space, are discarded whole and never become visible.

The write side is a state machine with states W_IDLE (waiting for a first byte), W_RECV (packing payload), W_DROP (discarding the rest of a lost frame), W_HDR_A (runt check, then signature write), W_HDR_B (length/status write and commit) and W_FLUSH (flush completion cycle). Its transitions are:
- W_IDLE to W_RECV on a first byte.
- W_RECV to W_HDR_A on the last byte.
- W_IDLE or W_RECV to W_DROP when a payload word finds no room.
- W_HDR_A to W_IDLE for a runt, otherwise to W_HDR_B.
- W_HDR_B to W_IDLE.
- Any state to W_FLUSH on a flush request.
- W_FLUSH to W_DROP if a frame was still arriving, otherwise to W_IDLE.

The read side has states R_SIG, R_LEN and R_BODY. It moves R_SIG to R_LEN to R_BODY with each word read, and goes from R_BODY back to R_SIG on the last payload word.

Top module: `rxf_framer`

## Requirements
- R1: After reset, frame_cnt is 0, rx_irq is low, flush_busy is low and rd_data is 0.
- R2: The first word read for every stored frame is 0x0143414D.
- R3: The second word read for a frame carries the frame's byte count (CRC bytes included) in bits 15:0 and the in_stat value given with its last byte in bits 31:16, unchanged (CRC error flag at bit 4, length error flags at bits 6:5).
- R4: Payload follows as ceil(count/4) words, little-endian: byte k of the frame sits in word k/4 at bits 8*(k%4)+7 down to 8*(k%4). Lanes past the last byte read as zero.
- R5: A frame of fewer than MIN_LEN (default 64) bytes is discarded whole, is not counted, and leaves nothing to read.
- R6: frame_cnt rises by one when a frame is committed (visible by the third cycle after its last byte). It falls by one in the cycle the last payload word of a frame is read. The MAC leaves in_valid low for the two cycles after a last byte.
- R7: rx_irq is high exactly when frame_cnt is non-zero.
- R8: A frame whose payload does not fit in the free FIFO space is discarded whole and not counted; frames stored earlier stay intact and readable.
- R9: A read when no committed word is waiting returns 0 on rd_data and does not advance the read position.
- R10: A cnt_clr pulse sets frame_cnt to 0 without disturbing stored data, which stays readable in order.
- R11: A flush_go pulse empties the FIFO and zeroes frame_cnt. flush_busy is high in the following cycle and low after it. A frame arriving at the time of the flush is discarded up to and including its last byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A frame byte is present this cycle |
| in_first | input | 1 | The byte is the first of a frame |
| in_last | input | 1 | The byte is the last of a frame |
| in_byte | input | 8 | Frame byte |
| in_stat | input | 16 | Receive status, sampled with the last byte |
| rd_en | input | 1 | Read one word from the data port |
| rd_data | output | 32 | Word read, valid the cycle after rd_en |
| cnt_clr | input | 1 | Zero the frame counter |
| frame_cnt | output | ADDR_W+1 | Number of complete frames waiting |
| flush_go | input | 1 | Start a FIFO flush |
| flush_busy | output | 1 | Flush is completing |
| rx_irq | output | 1 | Receive interrupt level |

## Verification
The bench aims at partial last words, because a design that mis-sizes the word count or leaves stale lanes would shift every later frame off its signature. It sends runts and a frame that overflows the FIFO behind stored frames. A design that commits either one, or that loses the frames already queued, shows a wrong count or a corrupt read-back. It reads from an empty FIFO and then stores a frame. A design that moves its read pointer on an empty read would return that frame misaligned. It also flushes in the middle of an arriving frame, where a design that stops discarding at the flush would commit the frame's tail as a new frame.

// File: rtl/rxf_pkg.sv
package rxf_pkg;

    localparam logic [31:0] FRAME_SIG = 32'h0143414D;

    typedef enum logic [2:0] {
        W_IDLE,
        W_RECV,
        W_DROP,
        W_HDR_A,
        W_HDR_B,
        W_FLUSH
    } wr_state_e;

    typedef enum logic [1:0] {
        R_SIG,
        R_LEN,
        R_BODY
    } rd_state_e;

endpackage

// File: rtl/rxf_store.sv
module rxf_store #(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [31:0]       wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [31:0]       rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [31:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];

endmodule

// File: rtl/rxf_writer.sv
module rxf_writer
    import rxf_pkg::*;
#(
    parameter int ADDR_W  = 8,
    parameter int MIN_LEN = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              in_first,
    input  logic              in_last,
    input  logic [7:0]        in_byte,
    input  logic [15:0]       in_stat,
    input  logic              flush_go,
    input  logic [ADDR_W:0]   rd_ptr,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [31:0]       wr_data,
    output logic [ADDR_W:0]   commit_ptr,
    output logic              commit,
    output logic              flushing
);
    localparam int PW    = ADDR_W + 1;
    localparam int DEPTH = 1 << ADDR_W;

    wr_state_e     state, nstate;
    logic [PW-1:0] wp;
    logic [15:0]   bc;
    logic [23:0]   acc;
    logic [15:0]   stat_q;
    logic          open_q;

    logic          start, take, need_wr, room, lost, runt, open_now;
    logic [PW-1:0] eff_wp, used_after, occ;
    logic [15:0]   eff_bc;
    logic [23:0]   eff_acc;
    logic [1:0]    lane;
    logic [31:0]   cur_word;

    assign start      = (state == W_IDLE) && in_valid && in_first;
    assign take       = start || ((state == W_RECV) && in_valid);
    assign eff_wp     = start ? commit_ptr + PW'(2) : wp;
    assign eff_bc     = start ? 16'd0 : bc;
    assign eff_acc    = start ? 24'd0 : acc;
    assign lane       = eff_bc[1:0];
    assign cur_word   = {8'h00, eff_acc} | ({24'h0, in_byte} << {lane, 3'b000});
    assign need_wr    = take && ((lane == 2'd3) || in_last);
    assign used_after = eff_wp - rd_ptr;
    assign room       = used_after < PW'(DEPTH);
    assign lost       = need_wr && !room;
    assign runt       = bc < 16'(MIN_LEN);
    assign occ        = commit_ptr - rd_ptr;
    assign flushing   = (state == W_FLUSH);

    assign open_now = ((state == W_RECV) && !(in_valid && in_last))
                   || (start && !in_last)
                   || ((state == W_DROP) && !(in_valid && in_last));

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= W_IDLE;
        end else begin
            state <= nstate;
        end
    end

    // next state and write port
    always_comb begin
        nstate  = state;
        wr_en   = 1'b0;
        wr_addr = eff_wp[ADDR_W-1:0];
        wr_data = cur_word;
        commit  = 1'b0;
        unique case (state)
            W_IDLE, W_RECV: begin
                if (take) begin
                    wr_en = need_wr && room;
                    if (lost) begin
                        nstate = in_last ? W_IDLE : W_DROP;
                    end else begin
                        nstate = in_last ? W_HDR_A : W_RECV;
                    end
                end
            end
            W_DROP: begin
                if (in_valid && in_last) begin
                    nstate = W_IDLE;
                end
            end
            W_HDR_A: begin
                if (runt) begin
                    nstate = W_IDLE;
                end else begin
                    wr_en   = 1'b1;
                    wr_addr = commit_ptr[ADDR_W-1:0];
                    wr_data = FRAME_SIG;
                    nstate  = W_HDR_B;
                end
            end
            W_HDR_B: begin
                wr_en   = 1'b1;
                wr_addr = commit_ptr[ADDR_W-1:0] + ADDR_W'(1);
                wr_data = {stat_q, bc};
                commit  = 1'b1;
                nstate  = W_IDLE;
            end
            W_FLUSH: begin
                nstate = (open_q && !(in_valid && in_last)) ? W_DROP : W_IDLE;
            end
            default: nstate = W_IDLE;
        endcase
        if (flush_go) begin
            nstate = W_FLUSH;
            wr_en  = 1'b0;
            commit = 1'b0;
        end
    end

    // datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp         <= '0;
            commit_ptr <= '0;
            bc         <= '0;
            acc        <= '0;
            stat_q     <= '0;
            open_q     <= 1'b0;
        end else begin
            open_q <= open_now;
            if (flush_go) begin
                wp         <= '0;
                commit_ptr <= '0;
            end else begin
                if (take) begin
                    if (lost) begin
                        wp <= commit_ptr;
                    end else begin
                        wp  <= need_wr ? eff_wp + PW'(1) : eff_wp;
                        bc  <= eff_bc + 16'd1;
                        acc <= need_wr ? 24'd0 : cur_word[23:0];
                        if (in_last) begin
                            stat_q <= in_stat;
                        end
                    end
                end
                if ((state == W_HDR_A) && runt) begin
                    wp <= commit_ptr;
                end
                if (commit) begin
                    commit_ptr <= wp;
                end
            end
        end
    end

    AST_GAP_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == W_HDR_A) || (state == W_HDR_B)) |-> !in_valid); // R6

    AST_FIFO_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        occ <= PW'(DEPTH)); // R8

endmodule

// File: rtl/rxf_reader.sv
module rxf_reader
    import rxf_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clr,
    input  logic            rd_en,
    input  logic [ADDR_W:0] commit_ptr,
    input  logic [31:0]     mem_q,
    output logic [ADDR_W:0] rd_ptr,
    output logic [31:0]     rd_data,
    output logic            frame_done
);
    localparam int PW = ADDR_W + 1;

    rd_state_e   state, nstate;
    logic [14:0] left;
    logic        avail, pop;

    assign avail      = (rd_ptr != commit_ptr);
    assign pop        = rd_en && avail;
    assign frame_done = pop && (state == R_BODY) && (left == 15'd1);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            state <= R_SIG;
        end else begin
            state <= nstate;
        end
    end

    // next state
    always_comb begin
        nstate = state;
        unique case (state)
            R_SIG:   if (pop) nstate = R_LEN;
            R_LEN:   if (pop) nstate = R_BODY;
            R_BODY:  if (frame_done) nstate = R_SIG;
            default: nstate = R_SIG;
        endcase
    end

    // read datapath
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            rd_ptr  <= '0;
            rd_data <= '0;
            left    <= '0;
        end else if (pop) begin
            rd_ptr  <= rd_ptr + PW'(1);
            rd_data <= mem_q;
            if (state == R_LEN) begin
                left <= 15'((32'(mem_q[15:0]) + 32'd3) >> 2);
            end else if (state == R_BODY) begin
                left <= left - 15'd1;
            end
        end else if (rd_en) begin
            rd_data <= '0;
        end
    end

    AST_SIG_FOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && (state == R_SIG) && !clr) |-> (mem_q == FRAME_SIG)); // R2

    AST_EMPTY_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !avail && !clr) |=> (rd_data == 32'd0)); // R9

endmodule

// File: rtl/rxf_framer.sv
module rxf_framer
    import rxf_pkg::*;
#(
    parameter int ADDR_W  = 8,
    parameter int MIN_LEN = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              in_first,
    input  logic              in_last,
    input  logic [7:0]        in_byte,
    input  logic [15:0]       in_stat,
    input  logic              rd_en,
    output logic [31:0]       rd_data,
    input  logic              cnt_clr,
    output logic [ADDR_W:0]   frame_cnt,
    input  logic              flush_go,
    output logic              flush_busy,
    output logic              rx_irq
);
    localparam int CNT_W = ADDR_W + 1;

    logic              wr_en, commit, frame_done;
    logic [ADDR_W-1:0] wr_addr;
    logic [31:0]       wr_data, mem_q;
    logic [ADDR_W:0]   commit_ptr, rd_ptr;

    rxf_writer #(.ADDR_W(ADDR_W), .MIN_LEN(MIN_LEN)) u_wr (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .in_first   (in_first),
        .in_last    (in_last),
        .in_byte    (in_byte),
        .in_stat    (in_stat),
        .flush_go   (flush_go),
        .rd_ptr     (rd_ptr),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .commit_ptr (commit_ptr),
        .commit     (commit),
        .flushing   (flush_busy)
    );

    rxf_store #(.ADDR_W(ADDR_W)) u_mem (
        .clk   (clk),
        .we    (wr_en),
        .waddr (wr_addr),
        .wdata (wr_data),
        .raddr (rd_ptr[ADDR_W-1:0]),
        .rdata (mem_q)
    );

    rxf_reader #(.ADDR_W(ADDR_W)) u_rd (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr        (flush_go),
        .rd_en      (rd_en),
        .commit_ptr (commit_ptr),
        .mem_q      (mem_q),
        .rd_ptr     (rd_ptr),
        .rd_data    (rd_data),
        .frame_done (frame_done)
    );

    always_ff @(posedge clk) begin
        if (!rst_n || flush_go || cnt_clr) begin
            frame_cnt <= '0;
        end else if (commit && !frame_done) begin
            frame_cnt <= frame_cnt + CNT_W'(1);
        end else if (frame_done && !commit && (frame_cnt != '0)) begin
            frame_cnt <= frame_cnt - CNT_W'(1);
        end
    end

    assign rx_irq = (frame_cnt != '0);

    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        !(flush_go || cnt_clr) |=> ((frame_cnt == $past(frame_cnt))
            || (frame_cnt == $past(frame_cnt) + 1)
            || (frame_cnt + 1 == $past(frame_cnt)))); // R6

    AST_FLUSH_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        flush_go |=> (flush_busy && (frame_cnt == '0))); // R11

endmodule

// File: tb/sim_rxf_framer.sv
module sim_rxf_framer;
    localparam int AW    = 6;
    localparam int MINL  = 64;
    localparam int WORDS = 1 << AW;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        in_valid, in_first, in_last;
    logic [7:0]  in_byte;
    logic [15:0] in_stat;
    logic        rd_en, cnt_clr, flush_go;
    logic [31:0] rd_data;
    logic [AW:0] frame_cnt;
    logic        flush_busy, rx_irq;

    always #4 clk = ~clk;

    rxf_framer #(.ADDR_W(AW), .MIN_LEN(MINL)) u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_first(in_first),
        .in_last(in_last), .in_byte(in_byte), .in_stat(in_stat), .rd_en(rd_en),
        .rd_data(rd_data), .cnt_clr(cnt_clr), .frame_cnt(frame_cnt),
        .flush_go(flush_go), .flush_busy(flush_busy), .rx_irq(rx_irq)
    );

    int          n_chk = 0;
    int          n_err = 0;
    int          used  = 0;
    bit          fin   = 1'b0;
    logic [31:0] exp_q[$];

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] pat(int seed, int k);
        return 8'((seed * 13 + k * 7) & 255);
    endfunction

    // driver: sends a frame and pushes what must come back
    task automatic drive_frame(int len, logic [15:0] st, int seed, int flush_at);
        int nw;
        nw = (len + 3) / 4;
        for (int k = 0; k < len; k++) begin
            @(negedge clk);
            in_valid = 1'b1;
            in_first = (k == 0);
            in_last  = (k == len - 1);
            in_byte  = pat(seed, k);
            in_stat  = st;
            flush_go = (k == flush_at);
        end
        @(negedge clk);
        in_valid = 1'b0; in_first = 1'b0; in_last = 1'b0; flush_go = 1'b0;
        repeat (4) @(negedge clk);
        if (flush_at < 0 && len >= MINL && used + 2 + nw <= WORDS) begin
            exp_q.push_back(32'h0143414D);
            exp_q.push_back({st, 16'(len)});
            for (int w = 0; w < nw; w++) begin
                logic [31:0] word;
                word = '0;
                for (int b = 0; b < 4; b++)
                    if (4 * w + b < len) word[8*b +: 8] = pat(seed, 4 * w + b);
                exp_q.push_back(word);
            end
            used += 2 + nw;
        end
    endtask

    // monitor: reads one frame and compares against the queue
    task automatic read_frame(int len);
        int nw;
        nw = (len + 3) / 4;
        for (int i = 0; i < nw + 2; i++) begin
            logic [31:0] e;
            @(negedge clk);
            rd_en = 1'b1;
            @(negedge clk);
            rd_en = 1'b0;
            e = (exp_q.size() > 0) ? exp_q.pop_front() : 32'hDEADBEEF;
            used--;
            if (i == 0)      chk("R2 signature", rd_data, e);
            else if (i == 1) chk("R3 length/status", rd_data, e);
            else             chk("R4 payload", rd_data, e);
        end
    endtask

    task automatic empty_read(string req);
        @(negedge clk);
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        chk(req, rd_data, 32'd0);
    endtask

    initial begin
        rst_n = 1'b0; in_valid = 1'b0; in_first = 1'b0; in_last = 1'b0;
        in_byte = '0; in_stat = '0; rd_en = 1'b0; cnt_clr = 1'b0; flush_go = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1
        chk("R1 count", 32'(frame_cnt), 0);
        chk("R1 irq", 32'(rx_irq), 0);
        chk("R1 busy", 32'(flush_busy), 0);
        chk("R1 data", rd_data, 0);

        // minimum-size frame
        drive_frame(64, 16'h0000, 1, -1);
        chk("R6 count up", 32'(frame_cnt), 1);
        chk("R7 irq high", 32'(rx_irq), 1);
        read_frame(64);
        chk("R6 count down", 32'(frame_cnt), 0);
        chk("R7 irq low", 32'(rx_irq), 0);

        // partial last word, status flags passed through
        drive_frame(65, 16'h0070, 2, -1);
        read_frame(65);

        // runt
        drive_frame(63, 16'h0010, 3, -1);
        chk("R5 runt not counted", 32'(frame_cnt), 0);
        empty_read("R5 runt left nothing");

        // two frames, count steps
        drive_frame(64, 16'h0001, 4, -1);
        drive_frame(70, 16'h0020, 5, -1);
        chk("R6 two frames", 32'(frame_cnt), 2);
        read_frame(64);
        chk("R6 one left", 32'(frame_cnt), 1);
        read_frame(70);
        chk("R6 none left", 32'(frame_cnt), 0);

        // overflow: 22 words each, third does not fit in 64
        drive_frame(80, 16'h0002, 6, -1);
        drive_frame(80, 16'h0003, 7, -1);
        drive_frame(80, 16'h0004, 8, -1);
        chk("R8 overflow not counted", 32'(frame_cnt), 2);
        read_frame(80);
        read_frame(80);
        chk("R8 count after drain", 32'(frame_cnt), 0);
        empty_read("R8 dropped frame absent");

        // empty read must not move the read position
        empty_read("R9 empty read zero");
        drive_frame(66, 16'h0005, 9, -1);
        read_frame(66);

        // counter clear
        drive_frame(68, 16'h0006, 10, -1);
        @(negedge clk); cnt_clr = 1'b1;
        @(negedge clk); cnt_clr = 1'b0;
        chk("R10 count cleared", 32'(frame_cnt), 0);
        chk("R10 irq cleared", 32'(rx_irq), 0);
        read_frame(68);
        chk("R10 count stays zero", 32'(frame_cnt), 0);

        // flush with a stored frame
        drive_frame(64, 16'h0007, 11, -1);
        @(negedge clk); flush_go = 1'b1;
        @(negedge clk); flush_go = 1'b0;
        chk("R11 busy during flush", 32'(flush_busy), 1);
        chk("R11 count zeroed", 32'(frame_cnt), 0);
        @(negedge clk);
        chk("R11 busy released", 32'(flush_busy), 0);
        exp_q.delete();
        used = 0;
        empty_read("R11 fifo empty");

        // flush in the middle of an arriving frame
        drive_frame(64, 16'h0008, 12, 20);
        chk("R11 tail not committed", 32'(frame_cnt), 0);
        empty_read("R11 tail discarded");
        drive_frame(72, 16'h0009, 13, -1);
        chk("R11 next frame counted", 32'(frame_cnt), 1);
        read_frame(72);

        fin = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        #(8 * 100000);
        if (!fin) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

endmodule